// File: doc/BRIEF.md
# Binary-Tape Turing Machine Engine

This block executes a single-tape Turing machine in hardware. The tape is an on-chip row of `TAPE_LEN` one-bit squares and the control unit has four working states plus a terminal Halt state. A host programs an eight-entry rule table and fills the tape through simple write ports, both while the engine is idle. It then presents a start head position and a step budget, and pulses `start`.

The engine performs one complete machine step per clock while busy. In each step it reads the scanned square, writes the rule's symbol into that square, moves the head by one square and enters the rule's next state. It stops when the machine reaches Halt, when the head would leave the tape, or when the step budget runs out. It then raises `done` and holds the stop reason, the step count, the final head position and the final state until the next start. The tape can be read back bit by bit at any time through the host port. The engine does not try to decide in advance whether a machine halts; the step budget is the only guard.

Top module: `tm_engine`

## Requirements
- R1: After a synchronous active-low reset, busy and done are 0, stop_reason is 0, head_pos is 0, step_count is 0, cur_state is 0 (state A), and every tape square reads 0.
- R2: A rule is written at tbl_addr = {state[1:0], read symbol}, where A=0, B=1, C=2 and D=3. tbl_data = {next[2:0], write bit, direction}. Direction 1 moves the head to the next higher square and 0 to the next lower square. Any next value with bit 2 set means Halt, which cur_state then shows as 3'b100.
- R3: In every busy cycle that is not stopped by the budget, the engine writes the rule's bit into the scanned square, moves the head by exactly one square, takes the next state and adds one to step_count.
- R4: Squares never written read 0. Host tape writes made while idle are visible on tape_rdata at the addressed square. A start does not clear the tape, so its contents carry over from run to run.
- R5: A start pulse while idle loads head_pos from start_head, sets the state to A and step_count to 0, captures step_limit, clears done and raises busy on the next cycle.
- R6: A step whose next state is Halt completes its write and move, counts as a step, and ends the run with stop_reason 1.
- R7: A step that would move the head past square 0 or past square TAPE_LEN-1 still writes its bit and counts as a step. The head stays on the edge square, the state is unchanged, and the run ends with stop_reason 2. This takes precedence over Halt on the same step.
- R8: A busy cycle that begins with step_count equal to the captured limit performs no step and ends the run with stop_reason 3. A limit of 0 therefore stops with zero steps and the head on start_head.
- R9: Host writes to the rule table or the tape are ignored while busy.
- R10: busy and done are never high together. After a stop, done, stop_reason, step_count, head_pos and cur_state hold until the next start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Rule table write enable (idle only) |
| tbl_addr | input | 3 | Rule index {state, read symbol} |
| tbl_data | input | 5 | Rule {next state, write bit, direction} |
| tape_we | input | 1 | Host tape write enable (idle only) |
| tape_addr | input | $clog2(TAPE_LEN) | Host tape square for write and read-back |
| tape_wdata | input | 1 | Host tape write bit |
| tape_rdata | output | 1 | Content of square tape_addr |
| start | input | 1 | Begin a run when idle |
| start_head | input | $clog2(TAPE_LEN) | Initial head square |
| step_limit | input | CNT_W | Step budget for the run |
| busy | output | 1 | Engine stepping |
| done | output | 1 | Run finished, results valid |
| stop_reason | output | 2 | 0 none, 1 halt, 2 tape edge, 3 step budget |
| step_count | output | CNT_W | Steps executed in the run |
| head_pos | output | $clog2(TAPE_LEN) | Current head square |
| cur_state | output | 3 | Current control state (4 = Halt) |

## Verification
The hardest situations to reach are the collisions: a step that wants to halt while also stepping off the tape edge, and host traffic to the table, the tape and `start` arriving in the middle of a run. The stimulus places the head on the last square under a halting rule to force the first case. For the second, it keeps a two-state oscillating machine busy for hundreds of cycles and fires all three host writes during that window. It then reruns without reloading to show that the table kept its old rule. A sweep of generated rule tables, tapes and start squares is compared against a step-by-step model in the bench.

// File: rtl/tm_pkg.sv
// Package: shared types for the Turing machine engine.
// Assumes a binary alphabet and four working states plus Halt.
package tm_pkg;
    localparam int RULE_W   = 5;
    localparam int RULE_CNT = 8;
    localparam int IDX_W    = 3;

    localparam logic [2:0] ST_A    = 3'd0;
    localparam logic [2:0] ST_HALT = 3'b100;

    // Rule word: {next state, write bit, direction (1 = higher square)}
    typedef struct packed {
        logic [2:0] nxt;
        logic       wr;
        logic       dir;
    } tm_rule_t;

    typedef enum logic [1:0] {
        STOP_NONE  = 2'd0,
        STOP_HALT  = 2'd1,
        STOP_EDGE  = 2'd2,
        STOP_LIMIT = 2'd3
    } tm_stop_e;
endpackage

// File: rtl/tm_rule_table.sv
// Module: tm_rule_table
// Holds the eight transition rules and returns the rule selected by the
// engine's lookup index combinationally. Host writes land only while the
// engine is idle. Assumes the index is {state[1:0], read symbol}.
module tm_rule_table
    import tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_addr,
    input  tm_rule_t         host_data,
    input  logic [IDX_W-1:0] look_idx,
    output tm_rule_t         look_rule
);
    tm_rule_t                    ent [RULE_CNT];
    logic [RULE_CNT*RULE_W-1:0]  ent_flat;

    // Rule storage: cleared on reset, written by the host only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RULE_CNT; i++) ent[i] <= '0;
        end else if (host_we && !busy) begin
            ent[host_addr] <= host_data;
        end
    end

    // Lookup for the engine
    always_comb look_rule = ent[look_idx];

    // Flattened view of the table, used by the guard below
    generate
        for (genvar g = 0; g < RULE_CNT; g++) begin : g_flat
            assign ent_flat[g*RULE_W +: RULE_W] = ent[g];
        end
    endgenerate

    // R9: table contents never change while a run is in progress
    a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ent_flat));
endmodule

// File: rtl/tm_tape.sv
// Module: tm_tape
// The tape: a row of TAPE_LEN one-bit squares with an engine port (read of
// the scanned square, one write per step) and a host port (write while idle,
// read at any time). Assumes TAPE_LEN is a power of two.
module tm_tape #(
    parameter int TAPE_LEN = 64,
    localparam int HEAD_W  = $clog2(TAPE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              eng_we,
    input  logic [HEAD_W-1:0] eng_addr,
    input  logic              eng_bit,
    output logic              eng_rd,
    input  logic              host_we,
    input  logic [HEAD_W-1:0] host_addr,
    input  logic              host_wdata,
    output logic              host_rdata
);
    logic [TAPE_LEN-1:0] sq;
    logic                chk_arm;
    logic [HEAD_W-1:0]   chk_addr;
    logic                chk_old;

    // Square storage: blank on reset; engine writes while busy, host while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq <= '0;
        end else if (eng_we) begin
            sq[eng_addr] <= eng_bit;
        end else if (host_we && !busy) begin
            sq[host_addr] <= host_wdata;
        end
    end

    // Read ports
    always_comb begin
        eng_rd     = sq[eng_addr];
        host_rdata = sq[host_addr];
    end

    // Guard bookkeeping: remember a host write attempted during a run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_arm  <= 1'b0;
            chk_addr <= '0;
            chk_old  <= 1'b0;
        end else begin
            chk_arm  <= busy && host_we && !(eng_we && eng_addr == host_addr);
            chk_addr <= host_addr;
            chk_old  <= sq[host_addr];
        end
    end

    // R9: a host write issued while busy leaves its square untouched
    always_ff @(posedge clk) begin
        if (rst_n && chk_arm) begin
            a_r9_tape_locked: assert (sq[chk_addr] == chk_old);
        end
    end
endmodule

// File: rtl/tm_control.sv
// Module: tm_control
// Finite control of the engine: run/stop sequencing, head position, present
// state and step counter. One full machine step per busy cycle using the
// rule handed in by the table. Assumes the scanned bit is read combinationally.
module tm_control
    import tm_pkg::*;
#(
    parameter int TAPE_LEN = 64,
    parameter int CNT_W    = 16,
    localparam int HEAD_W  = $clog2(TAPE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HEAD_W-1:0] start_head,
    input  logic [CNT_W-1:0]  step_limit,
    input  logic              rd_bit,
    input  tm_rule_t          rule,
    output logic [IDX_W-1:0]  look_idx,
    output logic              eng_we,
    output logic              eng_bit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        reason,
    output logic [HEAD_W-1:0] head,
    output logic [2:0]        state,
    output logic [CNT_W-1:0]  step_count
);
    localparam logic [HEAD_W-1:0] LAST_SQ = HEAD_W'(TAPE_LEN - 1);

    logic [CNT_W-1:0] limit_q;
    logic             limit_hit;
    logic             edge_hit;
    logic             to_halt;

    // Step decode: rule index, budget and edge conditions, engine write
    always_comb begin
        look_idx  = {state[1:0], rd_bit};
        limit_hit = (step_count == limit_q);
        edge_hit  = rule.dir ? (head == LAST_SQ) : (head == '0);
        to_halt   = rule.nxt[2];
        eng_we    = busy && !limit_hit;
        eng_bit   = rule.wr;
    end

    // Run sequencing and machine step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            reason     <= STOP_NONE;
            head       <= '0;
            state      <= ST_A;
            step_count <= '0;
            limit_q    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy       <= 1'b1;
                done       <= 1'b0;
                reason     <= STOP_NONE;
                head       <= start_head;
                state      <= ST_A;
                step_count <= '0;
                limit_q    <= step_limit;
            end
        end else if (limit_hit) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            reason <= STOP_LIMIT;
        end else begin
            step_count <= step_count + 1'b1;
            if (edge_hit) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                reason <= STOP_EDGE;
            end else begin
                head  <= rule.dir ? head + 1'b1 : head - 1'b1;
                state <= to_halt ? ST_HALT : rule.nxt;
                if (to_halt) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    reason <= STOP_HALT;
                end
            end
        end
    end

    // R3: each executed step advances the count by one
    a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !limit_hit |=> step_count == $past(step_count) + 1'b1);

    // R3: the head moves exactly one square on an in-range step
    a_r3_head_one_square: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !limit_hit && !edge_hit |=>
            (head == $past(head) + 1'b1) || (head == $past(head) - 1'b1));

    // R6: a halting rule ends the run in the Halt state
    a_r6_halt_stop: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !limit_hit && !edge_hit && to_halt |=>
            done && reason == STOP_HALT && state == ST_HALT);

    // R7: stepping off the tape keeps the head on the edge square
    a_r7_edge_stop: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !limit_hit && edge_hit |=>
            done && reason == STOP_EDGE && $stable(head) && $stable(state));

    // R8: the count never passes the captured budget
    a_r8_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> step_count <= limit_q);

    // R10: running and finished are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10: results hold after a stop until the next start
    a_r10_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(step_count) && $stable(head)
            && $stable(reason) && $stable(state));
endmodule

// File: rtl/tm_engine.sv
// Module: tm_engine (top)
// Single-tape binary Turing machine: rule table, tape and finite control
// wired together. Host programs table and tape while idle, then pulses start.
// Assumes TAPE_LEN is a power of two.
module tm_engine
    import tm_pkg::*;
#(
    parameter int TAPE_LEN = 64,
    parameter int CNT_W    = 16,
    localparam int HEAD_W  = $clog2(TAPE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [2:0]        tbl_addr,
    input  logic [4:0]        tbl_data,
    input  logic              tape_we,
    input  logic [HEAD_W-1:0] tape_addr,
    input  logic              tape_wdata,
    output logic              tape_rdata,
    input  logic              start,
    input  logic [HEAD_W-1:0] start_head,
    input  logic [CNT_W-1:0]  step_limit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        stop_reason,
    output logic [CNT_W-1:0]  step_count,
    output logic [HEAD_W-1:0] head_pos,
    output logic [2:0]        cur_state
);
    tm_rule_t          rule_w;
    logic [IDX_W-1:0]  idx_w;
    logic              rd_w;
    logic              eng_we_w;
    logic              eng_bit_w;

    tm_rule_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .host_we   (tbl_we),
        .host_addr (tbl_addr),
        .host_data (tm_rule_t'(tbl_data)),
        .look_idx  (idx_w),
        .look_rule (rule_w)
    );

    tm_tape #(.TAPE_LEN(TAPE_LEN)) u_tape (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .eng_we     (eng_we_w),
        .eng_addr   (head_pos),
        .eng_bit    (eng_bit_w),
        .eng_rd     (rd_w),
        .host_we    (tape_we),
        .host_addr  (tape_addr),
        .host_wdata (tape_wdata),
        .host_rdata (tape_rdata)
    );

    tm_control #(.TAPE_LEN(TAPE_LEN), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_head (start_head),
        .step_limit (step_limit),
        .rd_bit     (rd_w),
        .rule       (rule_w),
        .look_idx   (idx_w),
        .eng_we     (eng_we_w),
        .eng_bit    (eng_bit_w),
        .busy       (busy),
        .done       (done),
        .reason     (stop_reason),
        .head       (head_pos),
        .state      (cur_state),
        .step_count (step_count)
    );
endmodule

// File: tb/test_tm_engine.sv
module test_tm_engine;
    localparam int TL = 64;
    localparam int HW = 6;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [2:0]    tbl_addr = '0;
    logic [4:0]    tbl_data = '0;
    logic          tape_we = 1'b0;
    logic [HW-1:0] tape_addr = '0;
    logic          tape_wdata = 1'b0;
    logic          tape_rdata;
    logic          start = 1'b0;
    logic [HW-1:0] start_head = '0;
    logic [CW-1:0] step_limit = '0;
    logic          busy, done;
    logic [1:0]    stop_reason;
    logic [CW-1:0] step_count;
    logic [HW-1:0] head_pos;
    logic [2:0]    cur_state;

    tm_engine #(.TAPE_LEN(TL), .CNT_W(CW)) i_tm_engine (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .tape_we(tape_we), .tape_addr(tape_addr),
        .tape_wdata(tape_wdata), .tape_rdata(tape_rdata), .start(start),
        .start_head(start_head), .step_limit(step_limit), .busy(busy),
        .done(done), .stop_reason(stop_reason), .step_count(step_count),
        .head_pos(head_pos), .cur_state(cur_state)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [4:0]    m_tbl [8];
    logic [TL-1:0] m_tape;
    int            e_reason, e_steps, e_head, e_state;
    logic [TL-1:0] e_tape;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog
    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [31:0] rnd(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference machine built from the requirements
    task automatic model(input int sh, input int lim);
        int st = 0, cnt = 0, h = sh;
        logic [4:0] e;
        logic [TL-1:0] tp = m_tape;
        e_reason = 0;
        while (e_reason == 0) begin
            if (cnt == lim) begin e_reason = 3; break; end
            e = m_tbl[{st[1:0], tp[h]}];
            tp[h] = e[1];
            cnt++;
            if ((e[0] && h == TL-1) || (!e[0] && h == 0)) begin e_reason = 2; break; end
            h = e[0] ? h + 1 : h - 1;
            if (e[4]) begin st = 4; e_reason = 1; end
            else st = int'(e[4:2]);
        end
        e_steps = cnt; e_head = h; e_state = st; e_tape = tp;
    endtask

    task automatic push_table();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); tbl_we = 1'b1; tbl_addr = 3'(i); tbl_data = m_tbl[i];
        end
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic push_tape();
        for (int i = 0; i < TL; i++) begin
            @(negedge clk); tape_we = 1'b1; tape_addr = HW'(i); tape_wdata = m_tape[i];
        end
        @(negedge clk); tape_we = 1'b0;
    endtask

    task automatic kick(input int sh, input int lim);
        @(negedge clk);
        start_head = HW'(sh); step_limit = CW'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk(n < 3000, req, "run finished", n, 3000);
    endtask

    task automatic verify(input string req);
        int bad = 0;
        chk(done == 1'b1 && busy == 1'b0, "R10", "done/busy", {done, busy}, 2);
        chk(stop_reason == 2'(e_reason), req, "stop_reason", stop_reason, e_reason);
        chk(step_count == CW'(e_steps), req, "step_count", step_count, e_steps);
        chk(head_pos == HW'(e_head), req, "head_pos", head_pos, e_head);
        chk(cur_state == 3'(e_state), req, "cur_state", cur_state, e_state);
        for (int i = 0; i < TL; i++) begin
            tape_addr = HW'(i); #1;
            if (tape_rdata !== e_tape[i]) bad++;
        end
        chk(bad == 0, "R4", "tape mismatching squares", bad, 0);
    endtask

    task automatic run_case(input int sh, input int lim, input string req);
        model(sh, lim);
        kick(sh, lim);
        wait_done(req);
        verify(req);
        m_tape = e_tape;
    endtask

    function automatic logic [4:0] rule(input int nx, input int wr, input int dr);
        return {3'(nx), 1'(wr), 1'(dr)};
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
        chk(stop_reason == 0, "R1", "stop_reason", stop_reason, 0);
        chk(head_pos == 0, "R1", "head_pos", head_pos, 0);
        chk(step_count == 0, "R1", "step_count", step_count, 0);
        chk(cur_state == 0, "R1", "cur_state", cur_state, 0);
        begin
            int ones = 0;
            for (int i = 0; i < TL; i++) begin
                tape_addr = HW'(i); #1; ones += int'(tape_rdata);
            end
            chk(ones == 0, "R1", "tape ones after reset", ones, 0);
        end
        for (int i = 0; i < 8; i++) m_tbl[i] = '0;
        m_tape = '0;

        // R6 / R2: fill ones rightward until a 1 is read, then halt
        m_tbl[0] = rule(0, 1, 1);
        m_tbl[1] = rule(4, 1, 1);
        push_table();
        m_tape = '0; m_tape[5] = 1'b1;
        push_tape();
        run_case(0, 100, "R6");
        chk(step_count == 6 && head_pos == 6, "R6", "halt steps*100+head",
            step_count * 100 + head_pos, 606);

        // R7: run off the high edge
        m_tbl[0] = rule(0, 1, 1); m_tbl[1] = rule(0, 1, 1);
        push_table();
        m_tape = '0; push_tape();
        run_case(60, 100, "R7");
        chk(step_count == 4 && head_pos == 63, "R7", "high edge steps*100+head",
            step_count * 100 + head_pos, 463);

        // R7: run off the low edge
        m_tbl[0] = rule(0, 1, 0); m_tbl[1] = rule(0, 1, 0);
        push_table();
        m_tape = '0; push_tape();
        run_case(2, 100, "R7");
        chk(step_count == 3 && head_pos == 0, "R7", "low edge steps*100+head",
            step_count * 100 + head_pos, 300);

        // R7: edge wins over halt on the same step
        m_tbl[0] = rule(4, 1, 1); m_tbl[1] = rule(4, 1, 1);
        push_table();
        m_tape = '0; push_tape();
        run_case(63, 100, "R7");
        chk(stop_reason == 2, "R7", "edge over halt reason", stop_reason, 2);

        // R8: oscillating machine under a budget, and a zero budget
        m_tbl[0] = rule(1, 0, 1); m_tbl[1] = rule(1, 1, 1);
        m_tbl[2] = rule(0, 0, 0); m_tbl[3] = rule(0, 1, 0);
        push_table();
        m_tape = '0; push_tape();
        run_case(30, 10, "R8");
        run_case(17, 0, "R8");
        chk(step_count == 0 && head_pos == 17, "R5", "zero budget head", head_pos, 17);

        // R9 / R10: host writes and a second start during a long run
        model(20, 200);
        kick(20, 200);
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R5", "busy during run", busy, 1);
        tape_we = 1'b1; tape_addr = 6'd40; tape_wdata = 1'b1;
        tbl_we = 1'b1; tbl_addr = 3'd0; tbl_data = rule(4, 1, 1);
        start = 1'b1; start_head = 6'd50; step_limit = 16'd3;
        @(negedge clk);
        tape_we = 1'b0; tbl_we = 1'b0; start = 1'b0;
        wait_done("R9");
        verify("R9");
        m_tape = e_tape;
        repeat (5) @(negedge clk);
        chk(done == 1 && step_count == 200, "R10", "held steps", step_count, 200);
        // table must still hold the oscillating rules
        run_case(20, 5, "R9");

        // R3 / R4: sweep of generated machines, tapes and start squares
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 8; i++) begin
                seed = rnd(seed);
                m_tbl[i] = seed[4:0];
            end
            seed = rnd(seed); m_tape[31:0] = seed;
            seed = rnd(seed); m_tape[63:32] = seed;
            push_table();
            push_tape();
            seed = rnd(seed);
            run_case(int'(seed[5:0]), 40, "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule